// File: doc/BRIEF.md
# Timing Pulse and Interval Flag Generator

This block produces the single timing-pulse output of a real-time-clock device. A free-running divider counts a 32768 Hz clock-enable tick. The output pin carries one of two things. It can carry a fixed 50 % duty square wave taken from a divider bit. It can instead carry a latched interval flag, which is raised each time a whole number of seconds (1, 10, 30 or 60) has passed.

Commands arrive as a 4-bit code qualified by a one-cycle strobe. A separate qualifier marks codes that came through the serial command path. Commands can do the following:
- choose a wave or an interval period
- clear the flag
- restart the interval counter and let it run
- freeze the interval counter without touching the output level

A command takes effect on the clock edge that samples its strobe. With the divider width `DIV_W`, one second is 2^DIV_W ticks. The width must be at least 9, and its default of 15 gives true seconds at 32768 Hz.

Top module: `tp_pulse_gen`

## Requirements
- R1: After reset the output is low and shows the interval flag, the flag is clear, the interval counter is stopped and the selected period is 1 s; with no command the output stays low.
- R2: The divider advances by one on every cycle with `tick` high, wraps every 2^DIV_W ticks (one second boundary), and is never altered by any command, so wave phase depends only on the tick count since reset.
- R3: Codes 4'b0100, 4'b0101 and 4'b0110 select a wave equal to divider bit 8, bit 6 and bit 3 respectively (64 Hz, 256 Hz, 2048 Hz at 32768 Hz, 50 % duty).
- R4: Code 4'b0111 selects divider bit 2 (4096 Hz) only when `cmd_serial` is high; with `cmd_serial` low it has no effect.
- R5: Selecting any wave stops the interval counter; it stays frozen until a restart or interval-set command.
- R6: Codes 4'b1000, 4'b1001, 4'b1010 and 4'b1011 select periods of 1, 10, 30 and 60 s, clear the flag, zero the counter, start it, and route the flag to the output.
- R7: A running counter raises the flag on the second boundary that completes the selected period, then restarts from zero; the flag stays high until cleared or until a new interval-set command.
- R8: Code 4'b1100 clears the flag and routes it to the output; the counter keeps its value and keeps counting.
- R9: Code 4'b1101 zeroes the counter, starts it and routes the flag to the output, leaving the flag itself unchanged.
- R10: Code 4'b1110 stops the counter; the output level and the flag do not change.
- R11: Codes 4'b0000 to 4'b0011 and 4'b1111 are ignored, and no code has any effect unless `cmd_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | 32768 Hz clock enable, one cycle wide |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 4 | Command code |
| cmd_serial | input | 1 | High when the command came from the serial path |
| tp | output | 1 | Timing-pulse output |

## Verification
Every cycle, the assertions check that the divider steps exactly with the tick. They check that the flag can rise only on a second boundary while the counter runs, and that the counter stays inside its period. They also check that a stopped counter is frozen, that a clear always leaves the flag low, that a wave mode never coexists with a running counter, and that state is untouched without a strobe.

Only the bench's scenarios show the rest. These are the exact second boundary on which each of the four periods fires, and the absolute phase of each wave against the tick count. They also cover the fact that a clear issued in mid-period does not delay the next flag. Finally, they show that the serial qualifier and the unused codes leave the output unchanged.

// File: rtl/tp_pkg.sv
package tp_pkg;

    localparam int CNT_W = 6;

    typedef enum logic {
        SRC_FLAG = 1'b0,
        SRC_WAVE = 1'b1
    } tp_src_e;

    typedef enum logic [1:0] {
        WAVE_64  = 2'd0,
        WAVE_256 = 2'd1,
        WAVE_2K  = 2'd2,
        WAVE_4K  = 2'd3
    } wave_e;

    typedef enum logic [1:0] {
        IVL_1S  = 2'd0,
        IVL_10S = 2'd1,
        IVL_30S = 2'd2,
        IVL_60S = 2'd3
    } ivl_e;

    // decoded command, at most one action bit set per strobe
    typedef struct packed {
        logic  set_wave;
        wave_e wave;
        logic  set_ivl;
        ivl_e  ivl;
        logic  clr_flag;
        logic  restart;
        logic  halt;
    } tp_cmd_t;

    typedef struct packed {
        ivl_e             sel;
        logic [CNT_W-1:0] cnt;
        logic             run;
        logic             flag;
    } ivl_state_t;

    typedef struct packed {
        tp_src_e src;
        wave_e   wave;
    } out_state_t;

    // seconds in each selectable period
    function automatic logic [CNT_W-1:0] ivl_len(input ivl_e s);
        case (s)
            IVL_1S:  return CNT_W'(1);
            IVL_10S: return CNT_W'(10);
            IVL_30S: return CNT_W'(30);
            default: return CNT_W'(60);
        endcase
    endfunction

    // divider bit giving each wave when the tick runs at 32768 Hz
    function automatic int wave_tap(input int w);
        case (w)
            0:       return 8;
            1:       return 6;
            2:       return 3;
            default: return 2;
        endcase
    endfunction

endpackage

// File: rtl/tp_cmd_decode.sv
module tp_cmd_decode
    import tp_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [3:0] cmd_code,
    input  logic       cmd_serial,
    output tp_cmd_t    cmd
);

    always_comb begin
        cmd = '0;
        if (cmd_valid) begin
            case (cmd_code)
                4'b0100: begin cmd.set_wave = 1'b1; cmd.wave = WAVE_64;  end
                4'b0101: begin cmd.set_wave = 1'b1; cmd.wave = WAVE_256; end
                4'b0110: begin cmd.set_wave = 1'b1; cmd.wave = WAVE_2K;  end
                4'b0111: begin
                    // fastest wave only reachable through the serial path
                    if (cmd_serial) begin
                        cmd.set_wave = 1'b1;
                        cmd.wave     = WAVE_4K;
                    end
                end
                4'b1000: begin cmd.set_ivl = 1'b1; cmd.ivl = IVL_1S;  end
                4'b1001: begin cmd.set_ivl = 1'b1; cmd.ivl = IVL_10S; end
                4'b1010: begin cmd.set_ivl = 1'b1; cmd.ivl = IVL_30S; end
                4'b1011: begin cmd.set_ivl = 1'b1; cmd.ivl = IVL_60S; end
                4'b1100: cmd.clr_flag = 1'b1;
                4'b1101: cmd.restart  = 1'b1;
                4'b1110: cmd.halt     = 1'b1;
                default: cmd = '0;
            endcase
        end
    end

endmodule

// File: rtl/tp_prescaler.sv
module tp_prescaler
    import tp_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    output logic       sec_pulse,
    output logic [3:0] taps
);

    logic [DIV_W-1:0] div_d, div_q;

    always_comb begin
        div_d = div_q;
        if (tick) begin
            div_d = div_q + DIV_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else begin
            div_q <= div_d;
        end
    end

    // the tick that wraps the divider marks a second boundary
    assign sec_pulse = tick & (&div_q);

    for (genvar i = 0; i < 4; i++) begin : g_tap
        localparam int TAP = wave_tap(i);
        assign taps[i] = div_q[TAP];
    end

    // R2: divider moves only with the tick, by exactly one
    a_r2_div_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (div_q == $past(div_q) + DIV_W'(1)));
    a_r2_div_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(div_q));

endmodule

// File: rtl/tp_interval.sv
module tp_interval
    import tp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sec_pulse,
    input  logic set_ivl,
    input  ivl_e ivl,
    input  logic clr_flag,
    input  logic restart,
    input  logic halt,
    output logic flag,
    output logic running
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    ivl_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;

        // free counting on second boundaries
        if (st_q.run && sec_pulse) begin
            if (st_q.cnt == ivl_len(st_q.sel) - ONE) begin
                st_d.cnt  = '0;
                st_d.flag = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + ONE;
            end
        end

        // commands override the count on the same edge
        if (set_ivl) begin
            st_d.sel  = ivl;
            st_d.cnt  = '0;
            st_d.run  = 1'b1;
            st_d.flag = 1'b0;
        end else if (restart) begin
            st_d.cnt = '0;
            st_d.run = 1'b1;
        end else if (halt) begin
            st_d.run = 1'b0;
        end else if (clr_flag) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{sel: IVL_1S, cnt: '0, run: 1'b0, flag: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flag    = st_q.flag;
    assign running = st_q.run;

    // R7: flag can only be raised by a running counter at a second boundary
    a_r7_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.flag && !(sec_pulse && st_q.run)) |=> !st_q.flag);
    // R7: count never leaves its period
    a_r7_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt < ivl_len(st_q.sel));
    // R10: a stopped counter is frozen until restarted
    a_r10_halt_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.run && !set_ivl && !restart) |=> $stable(st_q.cnt));
    // R8: a clear always leaves the flag low
    a_r8_clear_low: assert property (@(posedge clk) disable iff (!rst_n)
        clr_flag |=> !st_q.flag);

endmodule

// File: rtl/tp_pulse_gen.sv
module tp_pulse_gen
    import tp_pkg::*;
#(
    parameter int DIV_W = 15
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       cmd_valid,
    input  logic [3:0] cmd_code,
    input  logic       cmd_serial,
    output logic       tp
);

    tp_cmd_t    cmd;
    logic       sec_pulse;
    logic [3:0] taps;
    logic       ivl_flag;
    logic       ivl_run;
    logic       halt_any;
    out_state_t out_d, out_q;

    tp_cmd_decode u_dec (
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .cmd_serial (cmd_serial),
        .cmd        (cmd)
    );

    tp_prescaler #(.DIV_W(DIV_W)) u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick      (tick),
        .sec_pulse (sec_pulse),
        .taps      (taps)
    );

    // a wave selection parks the interval counter
    assign halt_any = cmd.halt | cmd.set_wave;

    tp_interval u_ivl (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_pulse (sec_pulse),
        .set_ivl   (cmd.set_ivl),
        .ivl       (cmd.ivl),
        .clr_flag  (cmd.clr_flag),
        .restart   (cmd.restart),
        .halt      (halt_any),
        .flag      (ivl_flag),
        .running   (ivl_run)
    );

    always_comb begin
        out_d = out_q;
        if (cmd.set_wave) begin
            out_d.src  = SRC_WAVE;
            out_d.wave = cmd.wave;
        end else if (cmd.set_ivl || cmd.clr_flag || cmd.restart) begin
            out_d.src = SRC_FLAG;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{src: SRC_FLAG, wave: WAVE_64};
        end else begin
            out_q <= out_d;
        end
    end

    assign tp = (out_q.src == SRC_WAVE) ? taps[out_q.wave] : ivl_flag;

    // R5: while a wave is shown the interval counter is not running
    a_r5_wave_halts: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.src == SRC_WAVE) |-> !ivl_run);
    // R11: no strobe, no change of output routing
    a_r11_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(out_q));

endmodule

// File: tb/sim_tp_pulse_gen.sv
module sim_tp_pulse_gen;

    localparam int CLK_NS   = 10;
    localparam int DIVW     = 9;
    localparam int SEC      = 1 << DIVW;
    localparam int WD_LIMIT = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [3:0] cmd_code = 4'b0000;
    logic       cmd_serial = 1'b0;
    logic       tp;

    tp_pulse_gen #(.DIV_W(DIVW)) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .cmd_valid  (cmd_valid),
        .cmd_code   (cmd_code),
        .cmd_serial (cmd_serial),
        .tp         (tp)
    );

    always #(CLK_NS/2) clk = ~clk;

    typedef struct {
        int    at;
        bit    val;
        string tag;
    } exp_t;

    exp_t q[$];
    int   vectors = 0;
    int   miscompares = 0;
    int   edges = 0;
    bit   done = 1'b0;

    // ticked edges since reset release; equals the divider value mod SEC
    always @(posedge clk) if (rst_n) edges <= edges + 1;

    task automatic compare(input bit v, input string tag);
        vectors++;
        if (tp !== v) begin
            miscompares++;
            $display("FAIL %s: tp=%0b expected %0b at edge %0d", tag, tp, v, edges);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        while (q.size() > 0 && q[0].at <= edges) begin
            exp_t e;
            e = q.pop_front();
            if (e.at < edges) begin
                vectors++;
                miscompares++;
                $display("FAIL %s: sample missed, actual edge %0d expected edge %0d",
                         e.tag, edges, e.at);
            end else begin
                compare(e.val, e.tag);
            end
        end
    end

    task automatic expect_at(input int at, input bit v, input string tag);
        exp_t e;
        int   pos;
        e.at  = at;
        e.val = v;
        e.tag = tag;
        pos = q.size();
        for (int i = 0; i < q.size(); i++) begin
            if (q[i].at > at) begin
                pos = i;
                break;
            end
        end
        q.insert(pos, e);
    endtask

    task automatic wait_to(input int t);
        while (edges < t) @(negedge clk);
    endtask

    task automatic issue(input logic [3:0] code, input logic ser, output int e);
        @(negedge clk);
        cmd_code   = code;
        cmd_serial = ser;
        cmd_valid  = 1'b1;
        @(negedge clk);
        cmd_valid  = 1'b0;
        cmd_serial = 1'b0;
        e = edges;
    endtask

    function automatic int wrap(input int e, input int n);
        return ((e / SEC) + n) * SEC;
    endfunction

    function automatic bit wbit(input int t, input int b);
        return bit'(((t % SEC) >> b) & 1);
    endfunction

    // push six wave samples spread over one second
    task automatic wave_samples(input int from, input int b, input string tag);
        for (int k = 0; k < 6; k++) begin
            expect_at(from + k * 97, wbit(from + k * 97, b), tag);
        end
    endtask

    initial begin
        #(CLK_NS * WD_LIMIT);
        vectors++;
        miscompares++;
        $display("FAIL watchdog: run still active, actual edge %0d expected end", edges);
        finish_run();
    end

    initial begin
        int e, e2, e3, e4, w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        tick  = 1'b1;
        compare(1'b0, "R1 reset low");
        expect_at(300, 1'b0, "R1 idle after reset");
        expect_at(SEC + 5, 1'b0, "R1 counter stopped at reset");
        wait_to(SEC + 5);

        // fixed waves, phase tied to absolute tick count
        issue(4'b0100, 1'b0, e);
        wave_samples(e + 1, 8, "R3 64Hz");
        wait_to(e + 1 + 5 * 97);
        issue(4'b0101, 1'b0, e);
        wave_samples(e + 1, 6, "R3 256Hz");
        wait_to(e + 1 + 5 * 97);
        issue(4'b0110, 1'b0, e);
        wave_samples(e + 1, 3, "R3 2048Hz R2 phase");
        wait_to(e + 1 + 5 * 97);
        issue(4'b0111, 1'b0, e);
        wave_samples(e + 1, 3, "R4 parallel 0111 ignored");
        wait_to(e + 1 + 5 * 97);
        issue(4'b0111, 1'b1, e);
        wave_samples(e + 1, 2, "R4 serial 4096Hz");
        wait_to(e + 1 + 5 * 97);
        issue(4'b0000, 1'b1, e);
        wave_samples(e + 1, 2, "R11 code 0000 ignored");
        wait_to(e + 1 + 5 * 97);
        issue(4'b1111, 1'b1, e);
        wave_samples(e + 1, 2, "R11 code 1111 ignored");
        wait_to(e + 1 + 5 * 97);
        @(negedge clk);
        cmd_code = 4'b1000;
        wave_samples(edges + 1, 2, "R11 no strobe");
        wait_to(edges + 1 + 5 * 97);
        cmd_code = 4'b0000;

        // 1 s interval
        issue(4'b1000, 1'b0, e);
        expect_at(e + 1, 1'b0, "R6 set shows cleared flag");
        expect_at(wrap(e, 1) - 1, 1'b0, "R7 before boundary");
        expect_at(wrap(e, 1), 1'b1, "R7 fires at 1 s");
        expect_at(wrap(e, 2) + 3, 1'b1, "R7 flag latched");
        wait_to(wrap(e, 2) + 20);
        issue(4'b1100, 1'b0, e2);
        expect_at(e2 + 1, 1'b0, "R8 clear");
        expect_at(wrap(e2, 1), 1'b1, "R8 counting continues");
        wait_to(wrap(e2, 1) + 20);

        // 10 s interval with a mid-period clear
        issue(4'b1001, 1'b0, e);
        expect_at(e + 1, 1'b0, "R6 new set clears flag");
        w = wrap(e, 10);
        wait_to(wrap(e, 3) + 100);
        issue(4'b1100, 1'b0, e2);
        expect_at(w - 1, 1'b0, "R6 10 s not early");
        expect_at(w, 1'b1, "R8 clear does not reset count");
        wait_to(w + 30);

        // restart keeps the flag, then period counts from restart
        issue(4'b1101, 1'b0, e3);
        expect_at(e3 + 1, 1'b1, "R9 flag kept on restart");
        wait_to(e3 + 40);
        issue(4'b1100, 1'b0, e4);
        expect_at(e4 + 1, 1'b0, "R8 clear after restart");
        expect_at(wrap(e3, 10) - 1, 1'b0, "R9 not early");
        expect_at(wrap(e3, 10), 1'b1, "R9 period from restart");
        wait_to(wrap(e3, 10) + 30);

        // stop keeps level, no firing while stopped
        issue(4'b1110, 1'b0, e);
        expect_at(e + 1, 1'b1, "R10 stop keeps level");
        expect_at(wrap(e, 12) + 1, 1'b1, "R10 level held");
        wait_to(wrap(e, 12) + 1);
        issue(4'b1100, 1'b0, e2);
        expect_at(wrap(e2, 11) + 1, 1'b0, "R10 stopped counter silent");
        wait_to(wrap(e2, 11) + 1);
        issue(4'b1101, 1'b0, e3);
        expect_at(wrap(e3, 10) - 1, 1'b0, "R9 run after stop early");
        expect_at(wrap(e3, 10), 1'b1, "R9 run after stop");
        wait_to(wrap(e3, 10) + 20);

        // wave selection halts the counter
        issue(4'b1000, 1'b0, e);
        expect_at(wrap(e, 1), 1'b1, "R6 1 s again");
        wait_to(wrap(e, 1) + 20);
        issue(4'b0100, 1'b0, e2);
        wave_samples(e2 + 1, 8, "R5 wave shown");
        wait_to(e2 + 1 + 5 * 97);
        issue(4'b1100, 1'b0, e3);
        expect_at(e3 + 1, 1'b0, "R5 flag view cleared");
        expect_at(wrap(e3, 2) + 1, 1'b0, "R5 counter halted by wave");
        wait_to(wrap(e3, 2) + 1);

        // 30 s and 60 s
        issue(4'b1010, 1'b0, e);
        expect_at(wrap(e, 30) - 1, 1'b0, "R6 30 s not early");
        expect_at(wrap(e, 30), 1'b1, "R6 30 s fires");
        wait_to(wrap(e, 30) + 20);
        issue(4'b1011, 1'b0, e);
        expect_at(e + 1, 1'b0, "R6 60 s set clears flag");
        expect_at(wrap(e, 60) - 1, 1'b0, "R6 60 s not early");
        expect_at(wrap(e, 60), 1'b1, "R6 60 s fires");
        wait_to(wrap(e, 60) + 20);

        @(negedge clk);
        finish_run();
    end

endmodule